// File: doc/BRIEF.md
# Output Compare Event Generator

One timer channel that drives an output pin when a selected 16-bit time base reaches a computed match time. On a start request the channel latches its settings and forms the match time as reference time plus offset, wrapping modulo 2^16. It can also set the pin to a known level at that moment. From then on it watches the chosen time base for an exact equality with the match register.

The same comparator serves three modes. A single transition applies one pin action and stops. A single pulse applies the action at the first match, then returns the pin to its earlier level one offset later. A continuous square wave toggles the pin at every match and moves the match time forward by the offset each time, so the offset is the half-period. Every match raises a one-cycle interrupt strobe.

Top module: `outputCompareChannel`

## Requirements
- R1: At a start, the match time becomes (reference time + offset) modulo 2^16, computed once from the values present in the start cycle.
- R2: Time-base select 0 compares against time base A and select 1 against time base B. The unselected base has no effect on matches.
- R3: At a start, pin-state code 01 drives the pin high and code 10 drives it low. Codes 00 and 11 leave the pin unchanged. The new level is visible in the cycle after the start edge.
- R4: Mode 00 (single transition): at the first match the pin action is applied (00 none, 01 high, 10 low, 11 toggle), and the channel then goes idle and ignores later equalities.
- R5: Mode 01 (single pulse): the first match applies the pin action and sets a second match time of first match + offset. At the second match the pin returns to the level it held just before the first match, and the channel goes idle.
- R6: Mode 10 (continuous): every match toggles the pin and loads the next match time as the current match time + offset.
- R7: The interrupt output is high for exactly the one cycle after each match edge and low otherwise.
- R8: A start while the channel is busy restarts it with the new settings and takes priority over a match in the same cycle.
- R9: Mode 11 is reserved: a start with it is ignored, and the pin and channel state are unchanged.
- R10: Reset (active low) drives the pin low, the interrupt low and the channel idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| timeBaseA | input | 16 | First free-running time base |
| timeBaseB | input | 16 | Second time base |
| refTime | input | 16 | Reference time used at start |
| offset | input | 16 | Offset added to the reference; half-period in continuous mode |
| mode | input | 2 | 00 single transition, 01 pulse, 10 continuous, 11 reserved |
| baseSel | input | 1 | 0 selects timeBaseA, 1 selects timeBaseB |
| pinAct | input | 2 | Match action: 00 none, 01 high, 10 low, 11 toggle |
| pinState | input | 2 | Start level: 01 high, 10 low, 00/11 keep |
| start | input | 1 | One-cycle start request |
| pinOut | output | 1 | Channel pin level |
| matchIrq | output | 1 | One-cycle interrupt strobe per match |

## Verification
A wrong match register shows up at the ports as a pin edge and interrupt in the wrong cycle: early, late, or missing. The bench drives the exact time-base values around every match, so an off-by-one shows up in the cycle right after the intended match edge. A wrong phase in pulse or continuous mode shows up as a missing second edge, an extra interrupt once the channel should be idle, or a wrong restore level. Each of these is seen within one or two cycles of the match it concerns.

// File: rtl/ocPkg.sv
package ocPkg;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_PULSE  = 2'b01,
    MODE_CONT   = 2'b10,
    MODE_RSVD   = 2'b11
  } ocModeT;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SINGLE = 3'd1,
    ST_PULSE1 = 3'd2,
    ST_PULSE2 = 3'd3,
    ST_CONT   = 3'd4
  } ocStateT;

  // Strobes from control to datapath, valid for one edge
  typedef struct packed {
    logic load;       // latch settings, form match time, apply start level
    logic act;        // apply the latched pin action
    logic toggle;     // invert the pin
    logic restore;    // pin back to the saved level
    logic capRestore; // save the current pin level
    logic advance;    // match register += offset
    logic irq;        // raise the interrupt strobe
  } ocStrobeT;

endpackage

// File: rtl/ocControl.sv
module ocControl
  import ocPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] mode,
  input  logic       hit,
  output ocStrobeT   strb
);

  ocStateT state, stateNext;
  logic    startOk;

  assign startOk = start && (mode != MODE_RSVD);

  always_comb begin
    strb      = '0;
    stateNext = state;
    if (startOk) begin
      strb.load = 1'b1;
      unique case (ocModeT'(mode))
        MODE_SINGLE: stateNext = ST_SINGLE;
        MODE_PULSE:  stateNext = ST_PULSE1;
        default:     stateNext = ST_CONT;
      endcase
    end else if (hit) begin
      unique case (state)
        ST_SINGLE: begin
          strb.act  = 1'b1;
          strb.irq  = 1'b1;
          stateNext = ST_IDLE;
        end
        ST_PULSE1: begin
          strb.act        = 1'b1;
          strb.capRestore = 1'b1;
          strb.advance    = 1'b1;
          strb.irq        = 1'b1;
          stateNext       = ST_PULSE2;
        end
        ST_PULSE2: begin
          strb.restore = 1'b1;
          strb.irq     = 1'b1;
          stateNext    = ST_IDLE;
        end
        ST_CONT: begin
          strb.toggle  = 1'b1;
          strb.advance = 1'b1;
          strb.irq     = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  AST_PULSE_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PULSE2) |-> ($past(state) == ST_PULSE1 || $past(state) == ST_PULSE2)); // R5

  AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (start && mode == 2'b11 && state == ST_IDLE) |=> (state == ST_IDLE)); // R9

  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rstN)
    (start && mode != 2'b11) |=> (state != ST_IDLE)); // R8

endmodule

// File: rtl/ocDatapath.sv
module ocDatapath
  import ocPkg::*;
#(
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TIME_W-1:0] timeBaseA,
  input  logic [TIME_W-1:0] timeBaseB,
  input  logic [TIME_W-1:0] refTime,
  input  logic [TIME_W-1:0] offset,
  input  logic              baseSel,
  input  logic [1:0]        pinAct,
  input  logic [1:0]        pinState,
  input  ocStrobeT          strb,
  output logic              hit,
  output logic              pinOut,
  output logic              matchIrq
);

  logic [TIME_W-1:0] matchReg;
  logic [TIME_W-1:0] cfgOffset;
  logic              cfgSel;
  logic [1:0]        cfgAct;
  logic              pinReg;
  logic              restoreLvl;
  logic              irqReg;
  logic [TIME_W-1:0] selBase;

  assign selBase = cfgSel ? timeBaseB : timeBaseA;
  assign hit     = (selBase == matchReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchReg  <= '0;
      cfgOffset <= '0;
      cfgSel    <= 1'b0;
      cfgAct    <= 2'b00;
    end else if (strb.load) begin
      matchReg  <= refTime + offset;
      cfgOffset <= offset;
      cfgSel    <= baseSel;
      cfgAct    <= pinAct;
    end else if (strb.advance) begin
      matchReg  <= matchReg + cfgOffset;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinReg     <= 1'b0;
      restoreLvl <= 1'b0;
      irqReg     <= 1'b0;
    end else begin
      irqReg <= strb.irq;
      if (strb.capRestore) restoreLvl <= pinReg;
      if (strb.load) begin
        if (pinState == 2'b01)      pinReg <= 1'b1;
        else if (pinState == 2'b10) pinReg <= 1'b0;
      end else if (strb.act) begin
        unique case (cfgAct)
          2'b01:   pinReg <= 1'b1;
          2'b10:   pinReg <= 1'b0;
          2'b11:   pinReg <= ~pinReg;
          default: ;
        endcase
      end else if (strb.toggle) begin
        pinReg <= ~pinReg;
      end else if (strb.restore) begin
        pinReg <= restoreLvl;
      end
    end
  end

  assign pinOut   = pinReg;
  assign matchIrq = irqReg;

  AST_PIN_CAUSED: assert property (@(posedge clk) disable iff (!rstN)
    (pinReg != $past(pinReg)) |-> $past(strb.load || strb.act || strb.toggle || strb.restore)); // R3

  AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rstN)
    strb.toggle |=> (pinReg != $past(pinReg))); // R6

  AST_IRQ_FROM_HIT: assert property (@(posedge clk) disable iff (!rstN)
    irqReg |-> $past(hit)); // R7

endmodule

// File: rtl/outputCompareChannel.sv
module outputCompareChannel
  import ocPkg::*;
#(
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TIME_W-1:0] timeBaseA,
  input  logic [TIME_W-1:0] timeBaseB,
  input  logic [TIME_W-1:0] refTime,
  input  logic [TIME_W-1:0] offset,
  input  logic [1:0]        mode,
  input  logic              baseSel,
  input  logic [1:0]        pinAct,
  input  logic [1:0]        pinState,
  input  logic              start,
  output logic              pinOut,
  output logic              matchIrq
);

  ocStrobeT strb;
  logic     hit;

  ocControl uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .mode  (mode),
    .hit   (hit),
    .strb  (strb)
  );

  ocDatapath #(.TIME_W(TIME_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .timeBaseA (timeBaseA),
    .timeBaseB (timeBaseB),
    .refTime   (refTime),
    .offset    (offset),
    .baseSel   (baseSel),
    .pinAct    (pinAct),
    .pinState  (pinState),
    .strb      (strb),
    .hit       (hit),
    .pinOut    (pinOut),
    .matchIrq  (matchIrq)
  );

endmodule

// File: tb/sim_outputCompareChannel.sv
module sim_outputCompareChannel;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] timeBaseA = '0, timeBaseB = '0, refTime = '0, offset = '0;
  logic [1:0]  mode = '0, pinAct = '0, pinState = '0;
  logic        baseSel = 1'b0, start = 1'b0;
  logic        pinOut, matchIrq;
  int          checks = 0;
  int          errors = 0;

  always #4 clk = ~clk;

  outputCompareChannel u0 (
    .clk(clk), .rstN(rstN), .timeBaseA(timeBaseA), .timeBaseB(timeBaseB),
    .refTime(refTime), .offset(offset), .mode(mode), .baseSel(baseSel),
    .pinAct(pinAct), .pinState(pinState), .start(start),
    .pinOut(pinOut), .matchIrq(matchIrq)
  );

  typedef struct packed {
    logic        st;
    logic [1:0]  md;
    logic        sel;
    logic [1:0]  act;
    logic [1:0]  pst;
    logic [15:0] rf;
    logic [15:0] of;
    logic [15:0] ta;
    logic [15:0] tb;
    logic        ePin;
    logic        eIrq;
    logic [3:0]  req;
  } vecT;

  // Each row: inputs for one cycle, then pin/irq expected after that edge
  localparam int NV = 28;
  localparam vecT VEC [NV] = '{
    // single, base A, act high, start low: match 105 (R3, R4, R1)
    '{1'b1, 2'd0, 1'b0, 2'd1, 2'd2, 16'd100, 16'd5, 16'd0,   16'd0, 1'b0, 1'b0, 4'd3},
    '{1'b0, 2'd0, 1'b0, 2'd1, 2'd2, 16'd100, 16'd5, 16'd104, 16'd0, 1'b0, 1'b0, 4'd4},
    '{1'b0, 2'd0, 1'b0, 2'd1, 2'd2, 16'd100, 16'd5, 16'd105, 16'd0, 1'b1, 1'b1, 4'd1},
    '{1'b0, 2'd0, 1'b0, 2'd1, 2'd2, 16'd100, 16'd5, 16'd105, 16'd0, 1'b1, 1'b0, 4'd4},
    // pulse on base B, wrapped match 0x0002, second at 0x0006 (R2, R5)
    '{1'b1, 2'd1, 1'b1, 2'd1, 2'd2, 16'hFFFE, 16'd4, 16'd0, 16'd0, 1'b0, 1'b0, 4'd3},
    '{1'b0, 2'd1, 1'b1, 2'd1, 2'd2, 16'hFFFE, 16'd4, 16'd2, 16'd1, 1'b0, 1'b0, 4'd2},
    '{1'b0, 2'd1, 1'b1, 2'd1, 2'd2, 16'hFFFE, 16'd4, 16'd2, 16'd2, 1'b1, 1'b1, 4'd1},
    '{1'b0, 2'd1, 1'b1, 2'd1, 2'd2, 16'hFFFE, 16'd4, 16'd2, 16'd5, 1'b1, 1'b0, 4'd5},
    '{1'b0, 2'd1, 1'b1, 2'd1, 2'd2, 16'hFFFE, 16'd4, 16'd2, 16'd6, 1'b0, 1'b1, 4'd5},
    '{1'b0, 2'd1, 1'b1, 2'd1, 2'd2, 16'hFFFE, 16'd4, 16'd2, 16'd6, 1'b0, 1'b0, 4'd5},
    // continuous, start high, matches 13, 16, 19 (R6, R7)
    '{1'b1, 2'd2, 1'b0, 2'd0, 2'd1, 16'd10, 16'd3, 16'd0,  16'd0, 1'b1, 1'b0, 4'd3},
    '{1'b0, 2'd2, 1'b0, 2'd0, 2'd1, 16'd10, 16'd3, 16'd13, 16'd0, 1'b0, 1'b1, 4'd6},
    '{1'b0, 2'd2, 1'b0, 2'd0, 2'd1, 16'd10, 16'd3, 16'd14, 16'd0, 1'b0, 1'b0, 4'd7},
    '{1'b0, 2'd2, 1'b0, 2'd0, 2'd1, 16'd10, 16'd3, 16'd16, 16'd0, 1'b1, 1'b1, 4'd6},
    '{1'b0, 2'd2, 1'b0, 2'd0, 2'd1, 16'd10, 16'd3, 16'd19, 16'd0, 1'b0, 1'b1, 4'd6},
    '{1'b0, 2'd2, 1'b0, 2'd0, 2'd1, 16'd10, 16'd3, 16'd20, 16'd0, 1'b0, 1'b0, 4'd7},
    // single with toggle action, keep level at start (R3, R4)
    '{1'b1, 2'd0, 1'b0, 2'd3, 2'd3, 16'd0, 16'h20, 16'd0,   16'd0, 1'b0, 1'b0, 4'd3},
    '{1'b0, 2'd0, 1'b0, 2'd3, 2'd3, 16'd0, 16'h20, 16'h20,  16'd0, 1'b1, 1'b1, 4'd4},
    // reserved mode start ignored, pin stays high (R9)
    '{1'b1, 2'd3, 1'b0, 2'd0, 2'd2, 16'd0, 16'd1, 16'd0, 16'd0, 1'b1, 1'b0, 4'd9},
    '{1'b0, 2'd3, 1'b0, 2'd0, 2'd2, 16'd0, 16'd1, 16'd1, 16'd0, 1'b1, 1'b0, 4'd9},
    // restart beats a same-cycle match (R8)
    '{1'b1, 2'd0, 1'b0, 2'd2, 2'd3, 16'd50, 16'd0, 16'd49, 16'd0, 1'b1, 1'b0, 4'd3},
    '{1'b1, 2'd0, 1'b0, 2'd2, 2'd3, 16'd60, 16'd0, 16'd50, 16'd0, 1'b1, 1'b0, 4'd8},
    '{1'b0, 2'd0, 1'b0, 2'd2, 2'd3, 16'd60, 16'd0, 16'd50, 16'd0, 1'b1, 1'b0, 4'd8},
    '{1'b0, 2'd0, 1'b0, 2'd2, 2'd3, 16'd60, 16'd0, 16'd60, 16'd0, 1'b0, 1'b1, 4'd4},
    // low-active pulse with zero offset: back-to-back matches (R5)
    '{1'b1, 2'd1, 1'b0, 2'd2, 2'd1, 16'd200, 16'd0, 16'd0,   16'd0, 1'b1, 1'b0, 4'd3},
    '{1'b0, 2'd1, 1'b0, 2'd2, 2'd1, 16'd200, 16'd0, 16'd200, 16'd0, 1'b0, 1'b1, 4'd5},
    '{1'b0, 2'd1, 1'b0, 2'd2, 2'd1, 16'd200, 16'd0, 16'd200, 16'd0, 1'b1, 1'b1, 4'd5},
    '{1'b0, 2'd1, 1'b0, 2'd2, 2'd1, 16'd200, 16'd0, 16'd200, 16'd0, 1'b1, 1'b0, 4'd5}
  };

  task automatic check(input logic actPin, input logic actIrq,
                       input logic expPin, input logic expIrq, input int req);
    checks++;
    if (actPin !== expPin || actIrq !== expIrq) begin
      errors++;
      $display("FAIL R%0d pin=%b irq=%b expected pin=%b irq=%b", req,
               actPin, actIrq, expPin, expIrq);
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(pinOut, matchIrq, 1'b0, 1'b0, 10);
    rstN = 1'b1;
    @(negedge clk);
    check(pinOut, matchIrq, 1'b0, 1'b0, 10);

    for (int i = 0; i < NV; i++) begin
      start     = VEC[i].st;
      mode      = VEC[i].md;
      baseSel   = VEC[i].sel;
      pinAct    = VEC[i].act;
      pinState  = VEC[i].pst;
      refTime   = VEC[i].rf;
      offset    = VEC[i].of;
      timeBaseA = VEC[i].ta;
      timeBaseB = VEC[i].tb;
      @(negedge clk);
      check(pinOut, matchIrq, VEC[i].ePin, VEC[i].eIrq, int'(VEC[i].req));
    end

    // R10: reset while armed clears pin and cancels the pending match
    start = 1'b1; mode = 2'd0; baseSel = 1'b0; pinAct = 2'd2; pinState = 2'd1;
    refTime = 16'd300; offset = 16'd0; timeBaseA = 16'd0;
    @(negedge clk);
    check(pinOut, matchIrq, 1'b1, 1'b0, 3);
    start = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    check(pinOut, matchIrq, 1'b0, 1'b0, 10);
    rstN = 1'b1;
    timeBaseA = 16'd300;
    @(negedge clk);
    check(pinOut, matchIrq, 1'b0, 1'b0, 10);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule